// File: doc/BRIEF.md
# Clockless SAR Phase Sequencer

This block generates the timing frame for one successive-approximation conversion. It stays silent until it sees a sample request. A request starts a cascade of twelve pulse cells. Each cell holds its output high for a set number of ticks of a fast timebase. When a cell's pulse ends, that falling edge fires the next cell. The result is a contiguous, non-overlapping train of twelve phase pulses.

The phases carry fixed roles, in order:
- `phase[0]` is the sampling/precharge slot.
- `phase[1]` to `phase[9]` are the nine bit-decision slots.
- `phase[10]` is the output-capture slot.
- `phase[11]` is the switch-clear slot.

A small admission stage handles the sample input. It edge-detects the request, latches the pulse width for the whole frame, and rejects requests that arrive mid-frame. A rejected request raises a sticky overrun flag. The downstream converter logic decodes the one-hot `phase` bus to drive its capacitor switches and output register.

Top module: `phseq_frame`

## Requirements
- R1: Each accepted request yields exactly twelve pulses, one on each bit of `phase`, in ascending bit order from `phase[0]` to `phase[11]`. Bit 0 is the precharge slot, bits 1..9 are the decision slots, bit 10 is output capture and bit 11 is switch clear.
- R2: At most one bit of `phase` is high in any cycle.
- R3: Acceptance timing and pulse length:
  - A request accepted at clock edge t raises `phase[0]` right after edge t.
  - Each phase stays high for exactly W timebase cycles.
  - `phase[k+1]` rises at the same edge where `phase[k]` falls, so the frame lasts 12·W cycles with no gap.
- R4: W is the value of `width` captured at the accepting edge, with 0 treated as 1. Changing `width` during a frame has no effect on that frame.
- R5: Only a rising edge of `sample` starts a frame. Holding `sample` high produces a single frame and no further ones.
- R6: `busy` is high exactly while any phase is high, from the start of `phase[0]` to the end of `phase[11]`.
- R7: A rising edge of `sample` seen while `busy` is high is ignored. The frame in progress keeps its timing, and `overrun` is set at that edge.
- R8: `overrun` stays set until the next accepted request clears it at the accepting edge.
- R9: A synchronous active-low reset clears every phase, `busy` and `overrun`, including in the middle of a frame.
- R10: With no request, `phase` stays all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timebase |
| rst_n | input | 1 | Synchronous reset, active low |
| sample | input | 1 | Conversion request; its rising edge starts a frame |
| width | input | W_BITS | Pulse width in timebase cycles, captured per frame |
| phase | output | 12 | One-hot phase pulses, bit 0 first |
| busy | output | 1 | High while a frame runs |
| overrun | output | 1 | Sticky flag for a rejected request |

## Verification
The frame is driven with widths of 1, 3, 5 and 0. Against a per-cycle expected phase index, these show that the pulse length follows the captured width and that a zero width is clamped. A width change in mid-frame, a request held high as a level, and a second request pulse in mid-frame separate three cases: per-frame latching versus live width, edge triggering versus level triggering, and rejection versus restart. A reset in mid-frame and a long idle window confirm that nothing runs without a request.

// File: rtl/phseq_pkg.sv
package phseq_pkg;
   localparam int NUM_PHASES = 12;

   typedef enum int {
      PH_PRECHARGE = 0,
      PH_DECIDE_FIRST = 1,
      PH_DECIDE_LAST = 9,
      PH_CAPTURE = 10,
      PH_CLEAR = 11
   } phase_role_e;

   function automatic logic [31:0] clamp_width(input logic [31:0] w);
      return (w == 32'd0) ? 32'd1 : w;
   endfunction
endpackage

// File: rtl/phseq_cell.sv
module phseq_cell #(
   parameter int W_BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic [W_BITS-1:0] width,
   output logic              pulse,
   output logic              last
);
   logic              trig_q;
   logic [W_BITS-1:0] cnt;
   logic              fire;
   logic              armed;

   initial begin
      assert (W_BITS >= 1) else $error("phseq_cell: W_BITS must be at least 1");
   end

   assign fire = trig && !trig_q;
   assign last = pulse && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_q <= 1'b0;
         pulse  <= 1'b0;
         cnt    <= '0;
      end else begin
         trig_q <= trig;
         if (fire) begin
            pulse <= 1'b1;
            cnt   <= width - 1'b1;
         end else if (pulse) begin
            if (cnt == '0) pulse <= 1'b0;
            else cnt <= cnt - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) armed <= rst_n;

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (pulse && cnt != '0) |=> pulse);
   assert_end_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (last && !fire) |=> !pulse);
   assert_level_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (trig && trig_q && !pulse) |=> !pulse);
endmodule

// File: rtl/phseq_admit.sv
module phseq_admit
   import phseq_pkg::*;
#(
   parameter int W_BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic [W_BITS-1:0] width,
   input  logic              busy,
   output logic              go,
   output logic [W_BITS-1:0] width_use,
   output logic              overrun
);
   logic              sample_q;
   logic              rise;
   logic [W_BITS-1:0] width_lat;
   logic [W_BITS-1:0] width_clamped;
   logic              armed;

   assign rise          = sample && !sample_q;
   assign go            = rise && !busy;
   assign width_clamped = W_BITS'(clamp_width(32'(width)));
   assign width_use     = go ? width_clamped : width_lat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sample_q  <= 1'b0;
         width_lat <= W_BITS'(1);
         overrun   <= 1'b0;
      end else begin
         sample_q <= sample;
         if (go) begin
            width_lat <= width_clamped;
            overrun   <= 1'b0;
         end else if (rise && busy) begin
            overrun <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) armed <= rst_n;

   assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (rise && busy) |=> overrun);
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      go |=> !overrun);
   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (overrun && !go) |=> overrun);
   assert_width_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (width_use != '0));
endmodule

// File: rtl/phseq_frame.sv
module phseq_frame
   import phseq_pkg::*;
#(
   parameter int W_BITS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sample,
   input  logic [W_BITS-1:0]     width,
   output logic [NUM_PHASES-1:0] phase,
   output logic                  busy,
   output logic                  overrun
);
   localparam int LAST_IDX = NUM_PHASES - 1;

   logic              go;
   logic [W_BITS-1:0] width_use;
   logic [NUM_PHASES-1:0] cell_last;
   logic [NUM_PHASES-1:0] cell_trig;
   logic              armed;

   initial begin
      assert (NUM_PHASES == 12) else $error("phseq_frame: frame must have twelve phases");
      assert (W_BITS >= 1 && W_BITS <= 32) else $error("phseq_frame: W_BITS out of range");
   end

   assign busy = |phase;

   phseq_admit #(.W_BITS(W_BITS)) u_admit (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample    (sample),
      .width     (width),
      .busy      (busy),
      .go        (go),
      .width_use (width_use),
      .overrun   (overrun)
   );

   for (genvar k = 0; k < NUM_PHASES; k++) begin : g_cell
      if (k == 0) begin : g_head
         assign cell_trig[k] = go;
      end else begin : g_link
         assign cell_trig[k] = cell_last[k-1];
      end

      phseq_cell #(.W_BITS(W_BITS)) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .trig  (cell_trig[k]),
         .width (width_use),
         .pulse (phase[k]),
         .last  (cell_last[k])
      );
   end

   always_ff @(posedge clk) armed <= rst_n;

   assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $onehot0(phase));
   assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $rose(phase[0]) |-> $past(go));
   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (!busy && !go) |=> (phase == '0));

   for (genvar k = 0; k < LAST_IDX; k++) begin : g_chk
      assert_handoff_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         $fell(phase[k]) |-> phase[k+1]);
      assert_order_R1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         $rose(phase[k+1]) |-> $past(phase[k]));
   end
endmodule

// File: tb/sim_phseq_frame.sv
module sim_phseq_frame;
   localparam int CLK_PERIOD = 10;
   localparam int WB = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sample = 1'b0;
   logic [WB-1:0] width = 8'd3;
   logic [11:0]   phase;
   logic          busy;
   logic          overrun;

   int total = 0;
   int bad = 0;

   phseq_frame #(.W_BITS(WB)) u0 (
      .clk(clk), .rst_n(rst_n), .sample(sample), .width(width),
      .phase(phase), .busy(busy), .overrun(overrun)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Called at the negedge following the accepting edge.
   task automatic check_frame(input int w, input int pulse_at, input int chg_at, input string req);
      for (int i = 0; i < 12*w; i++) begin
         logic [11:0] exp;
         exp = 12'(1) << (i / w);
         chk(phase == exp && busy, req, {19'd0, busy, phase}, {19'd0, 1'b1, exp});
         if (i == pulse_at) sample = 1'b1;
         if (i == pulse_at + 1) sample = 1'b0;
         if (i == chg_at) width = 8'd1;
         @(negedge clk);
      end
      chk(phase == 12'd0 && !busy, {req, " end"}, {19'd0, busy, phase}, 32'd0);
   endtask

   task automatic request(input logic [WB-1:0] w);
      width = w;
      sample = 1'b1;
      @(negedge clk);
      sample = 1'b0;
   endtask

   task automatic t_reset_state();
      chk(phase == 12'd0, "R9 reset phase", 32'(phase), 32'd0);
      chk(!busy && !overrun, "R9 reset flags", {30'd0, busy, overrun}, 32'd0);
   endtask

   task automatic t_idle();
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         chk(phase == 12'd0 && !busy, "R10 idle", 32'(phase), 32'd0);
      end
   endtask

   task automatic t_widths();
      request(8'd3); check_frame(3, -1, -1, "R1 R3 R6 w3");
      request(8'd1); check_frame(1, -1, -1, "R3 w1");
      request(8'd0); check_frame(1, -1, -1, "R4 w0 clamp");
   endtask

   task automatic t_width_change();
      request(8'd5); check_frame(5, -1, 7, "R4 midframe width");
   endtask

   task automatic t_held_level();
      width = 8'd2;
      sample = 1'b1;
      @(negedge clk);
      check_frame(2, -1, -1, "R5 level");
      for (int i = 0; i < 20; i++) begin
         chk(phase == 12'd0, "R5 no retrigger", 32'(phase), 32'd0);
         @(negedge clk);
      end
      chk(!overrun, "R5 no overrun", 32'(overrun), 32'd0);
      sample = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_overrun();
      request(8'd4); check_frame(4, 10, -1, "R7 frame kept");
      chk(overrun, "R7 overrun set", 32'(overrun), 32'd1);
      repeat (5) @(negedge clk);
      chk(overrun, "R8 sticky", 32'(overrun), 32'd1);
      request(8'd2);
      chk(!overrun, "R8 cleared", 32'(overrun), 32'd0);
      check_frame(2, -1, -1, "R8 next frame");
   endtask

   task automatic t_mid_reset();
      request(8'd6);
      repeat (3) @(negedge clk);
      sample = 1'b1; @(negedge clk); sample = 1'b0;
      repeat (4) @(negedge clk);
      chk(busy && overrun, "R9 pre-reset", {30'd0, busy, overrun}, 32'd3);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk(phase == 12'd0 && !busy && !overrun, "R9 mid reset",
          {19'd0, overrun, phase}, 32'd0);
      repeat (80) @(negedge clk);
      chk(phase == 12'd0, "R9 stays quiet", 32'(phase), 32'd0);
   endtask

   task automatic finish_up();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      t_idle();
      t_widths();
      t_width_change();
      t_held_level();
      t_overrun();
      t_mid_reset();
      finish_up();
   end

   initial begin
      #(CLK_PERIOD * 100000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      finish_up();
   end
endmodule